// File: doc/BRIEF.md
# CAS-before-RAS refresh scheduler

This block keeps a dynamic memory's contents alive by issuing refresh cycles in which CAS falls before RAS. In these cycles the memory picks the row itself, so the scheduler drives only the two strobes and never an address. A free-running interval timer marks each slot in which a refresh falls due. Owed refreshes collect in a saturating counter. While at least one is owed, the block raises a request to the access controller. When that controller grants, the block drives the RAS/CAS waveform itself until the precharge has ended.

After reset the block holds the strobes quiet for a power-up pause. It then runs a fixed number of initialization refresh cycles on its own, without asking for a grant, and only afterwards raises `init_done_o`. The access controller must not start any cycle while that output is low. If, during normal running, neither the controller reports activity nor a refresh takes place for a long idle window, the block drops `init_done_o` and repeats the initialization cycles. This re-initialization has no pause. The owed-refresh count is left as it was.

All times are parameters in clock cycles. The defaults assume a 250 MHz clock: a 200 µs pause, 8 init cycles, one refresh every 15.6 µs, an 8 ms idle window, CAS setup and hold of 2 and 3 cycles, RAS low for 15 cycles and precharge for 10 cycles. That gives a 108 ns refresh cycle.

Top module: `cbr_refresh_sched`

## Requirements
- R1: While reset is asserted, `ras_n_o` and `cas_n_o` are 1 and `init_done_o`, `ref_req_o` and `ref_busy_o` are 0.
- R2: After reset is released, the strobes stay high for exactly INIT_WAIT cycles. The first CAS fall is observed in cycle INIT_WAIT+1, where cycle 1 is the first clock edge with reset released.
- R3: After the pause, exactly INIT_CYCLES refresh cycles run back to back, with one idle cycle between them. `init_done_o` rises in cycle INIT_WAIT + INIT_CYCLES*(T_CSR+T_RAS+T_RP+1), and `ref_req_o` is never high while `init_done_o` is low.
- R4: Every refresh cycle proceeds as follows. CAS (low active) falls with RAS high and stays alone for T_CSR cycles. RAS then falls, and both stay low for T_CHR cycles. CAS rises while RAS stays low for a further T_RAS-T_CHR cycles. Both strobes are then high for at least T_RP cycles before the next CAS fall. RAS never falls unless CAS is already low, and both strobes are high whenever `ref_busy_o` is 0.
- R5: One refresh falls due at every REF_INTERVAL-th clock edge from reset release, including during the pause and the init phase. `ref_req_o` is 1 exactly when `init_done_o` is 1, at least one refresh is owed, and no refresh cycle is underway.
- R6: When `ref_gnt_i` is 1 in a cycle in which `ref_req_o` is 1, CAS falls in the next cycle. Each refresh cycle that completes during normal running retires one owed refresh. Init cycles retire none.
- R7: The owed count saturates at MAX_PENDING. `ref_urgent_o` is 1 exactly when the count equals MAX_PENDING.
- R8: During normal running, suppose that for IDLE_LIMIT consecutive clock edges `act_i` is 0 and no refresh cycle is underway. Then `init_done_o` falls at the IDLE_LIMIT-th such edge. INIT_CYCLES cycles follow at once, with no pause, and `init_done_o` rises INIT_CYCLES*(T_CSR+T_RAS+T_RP+1) cycles after it fell. The owed count is unchanged by this.
- R9: Pulsing `act_i` more often than every IDLE_LIMIT cycles keeps `init_done_o` high.
- R10: `ref_gnt_i` while `ref_req_o` is 0 during normal running starts nothing: both strobes stay high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_i | input | 1 | Access controller ran a memory cycle this clock |
| ref_gnt_i | input | 1 | Access controller hands the strobes to the scheduler |
| ref_req_o | output | 1 | A refresh is owed and can start |
| ref_urgent_o | output | 1 | Owed count has reached its limit |
| ref_busy_o | output | 1 | Scheduler currently owns the strobes |
| ras_n_o | output | 1 | Row strobe, low active |
| cas_n_o | output | 1 | Column strobe, low active |
| init_done_o | output | 1 | Initialization finished; accesses allowed |

## Verification
The bench builds the block with INIT_WAIT=20, INIT_CYCLES=8, REF_INTERVAL=40, IDLE_LIMIT=300, MAX_PENDING=3 and strobe timings 2/3/6/4. With these values the power-up pause, every one of the init cycles, the saturation of the owed count and a full idle-triggered re-initialization all fit into a few thousand cycles. The owed count is tracked every cycle from the tick arithmetic and the observed retirements, and compared against the request and urgency outputs. The bench runs four grant policies in turn: none, always, only when urgent, and none again while idle. Every strobe phase length is measured against the parameters.

// File: rtl/cbr_sched_pkg.sv
package cbr_sched_pkg;

  typedef enum logic [2:0] {
    STB_IDLE,
    STB_SETUP,
    STB_OVERLAP,
    STB_RASONLY,
    STB_PRECH
  } stb_state_t;

  typedef enum logic [1:0] {
    CTL_PAUSE,
    CTL_INIT,
    CTL_RUN
  } ctl_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cbr_interval_timer.sv
module cbr_interval_timer #(
  parameter int PERIOD = 3900
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int W = $clog2(PERIOD + 1);
  localparam logic [W-1:0] LAST = W'(PERIOD - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else                  cnt <= cnt + 1'b1;
  end

  assign tick_o = (cnt == LAST);
endmodule

// File: rtl/cbr_pending_ctr.sv
module cbr_pending_ctr #(
  parameter int MAX_PENDING = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc_i,
  input  logic dec_i,
  output logic nonzero_o,
  output logic full_o
);
  localparam int W = $clog2(MAX_PENDING + 1);
  localparam logic [W-1:0] FULL = W'(MAX_PENDING);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 cnt <= '0;
    else if (inc_i && !dec_i && cnt != FULL)    cnt <= cnt + 1'b1;
    else if (dec_i && !inc_i && cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign nonzero_o = (cnt != '0);
  assign full_o    = (cnt == FULL);
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
  import cbr_sched_pkg::*;
#(
  parameter int T_CSR = 2,
  parameter int T_CHR = 3,
  parameter int T_RAS = 15,
  parameter int T_RP  = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic ras_n_o,
  output logic cas_n_o
);
  localparam int TMAX = imax(imax(T_CSR, T_CHR), imax(T_RAS, T_RP));
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] L_CSR = CW'(T_CSR - 1);
  localparam logic [CW-1:0] L_CHR = CW'(T_CHR - 1);
  localparam logic [CW-1:0] L_RAS = CW'(T_RAS - T_CHR - 1);
  localparam logic [CW-1:0] L_RP  = CW'(T_RP - 1);

  stb_state_t st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= STB_IDLE;
      cnt <= '0;
    end else if (st == STB_IDLE) begin
      if (start_i) begin
        st  <= STB_SETUP;
        cnt <= L_CSR;
      end
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end else begin
      case (st)
        STB_SETUP:   begin st <= STB_OVERLAP; cnt <= L_CHR; end
        STB_OVERLAP: begin st <= STB_RASONLY; cnt <= L_RAS; end
        STB_RASONLY: begin st <= STB_PRECH;   cnt <= L_RP;  end
        default:     begin st <= STB_IDLE;    cnt <= '0;    end
      endcase
    end
  end

  assign busy_o  = (st != STB_IDLE);
  assign done_o  = (st == STB_PRECH) && (cnt == '0);
  assign ras_n_o = !((st == STB_OVERLAP) || (st == STB_RASONLY));
  assign cas_n_o = !((st == STB_SETUP) || (st == STB_OVERLAP));
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
  import cbr_sched_pkg::*;
#(
  parameter int INIT_WAIT    = 50000,
  parameter int INIT_CYCLES  = 8,
  parameter int REF_INTERVAL = 3900,
  parameter int IDLE_LIMIT   = 2000000,
  parameter int MAX_PENDING  = 8,
  parameter int T_CSR        = 2,
  parameter int T_CHR        = 3,
  parameter int T_RAS        = 15,
  parameter int T_RP         = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_i,
  input  logic ref_gnt_i,
  output logic ref_req_o,
  output logic ref_urgent_o,
  output logic ref_busy_o,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic init_done_o
);
  localparam int PW = $clog2(INIT_WAIT + 1);
  localparam int IW = $clog2(INIT_CYCLES + 1);
  localparam int DW = $clog2(IDLE_LIMIT + 1);
  localparam logic [PW-1:0] P_LAST = PW'(INIT_WAIT - 1);
  localparam logic [IW-1:0] I_LAST = IW'(INIT_CYCLES - 1);
  localparam logic [DW-1:0] D_LAST = DW'(IDLE_LIMIT - 1);

  ctl_state_t    ctl;
  logic [PW-1:0] pause_cnt;
  logic [IW-1:0] init_cnt;
  logic [DW-1:0] idle_cnt;

  logic tick, pend_nz, pend_full;
  logic busy, done, start;

  cbr_interval_timer #(.PERIOD(REF_INTERVAL)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  cbr_pending_ctr #(.MAX_PENDING(MAX_PENDING)) u_pend (
    .clk(clk), .rst_n(rst_n),
    .inc_i(tick), .dec_i(done && (ctl == CTL_RUN)),
    .nonzero_o(pend_nz), .full_o(pend_full)
  );

  cbr_strobe_seq #(.T_CSR(T_CSR), .T_CHR(T_CHR), .T_RAS(T_RAS), .T_RP(T_RP)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_i(start),
    .busy_o(busy), .done_o(done), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o)
  );

  assign ref_req_o    = (ctl == CTL_RUN) && pend_nz && !busy;
  assign ref_urgent_o = pend_full;
  assign ref_busy_o   = busy;
  assign init_done_o  = (ctl == CTL_RUN);
  assign start        = ((ctl == CTL_INIT) && !busy) || (ref_req_o && ref_gnt_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl       <= CTL_PAUSE;
      pause_cnt <= '0;
      init_cnt  <= '0;
      idle_cnt  <= '0;
    end else begin
      case (ctl)
        CTL_PAUSE: begin
          if (pause_cnt == P_LAST) begin
            ctl      <= CTL_INIT;
            init_cnt <= '0;
          end else begin
            pause_cnt <= pause_cnt + 1'b1;
          end
        end
        CTL_INIT: begin
          if (done) begin
            if (init_cnt == I_LAST) begin
              ctl      <= CTL_RUN;
              idle_cnt <= '0;
            end else begin
              init_cnt <= init_cnt + 1'b1;
            end
          end
        end
        default: begin
          if (act_i || busy) begin
            idle_cnt <= '0;
          end else if (idle_cnt == D_LAST && !start) begin
            ctl      <= CTL_INIT;
            init_cnt <= '0;
            idle_cnt <= '0;
          end else if (idle_cnt != D_LAST) begin
            idle_cnt <= idle_cnt + 1'b1;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/cbr_refresh_sched_chk.sv
module cbr_refresh_sched_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_gnt_i,
  input logic ref_req_o,
  input logic ref_urgent_o,
  input logic ref_busy_o,
  input logic ras_n_o,
  input logic cas_n_o,
  input logic init_done_o
);
  p_cas_leads_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> ($past(cas_n_o) == 1'b0));

  p_cas_held_after_ras_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |=> !cas_n_o);

  p_quiet_when_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_busy_o |-> (ras_n_o && cas_n_o));

  p_no_req_before_init_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done_o |-> !ref_req_o);

  p_init_rise_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(init_done_o) |-> (ras_n_o && cas_n_o));

  p_grant_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_req_o && ref_gnt_i) |=> (!cas_n_o && ras_n_o));

  p_urgent_served_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ref_urgent_o |-> (ref_req_o || ref_busy_o || !init_done_o));
endmodule

bind cbr_refresh_sched cbr_refresh_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_gnt_i(ref_gnt_i), .ref_req_o(ref_req_o),
  .ref_urgent_o(ref_urgent_o), .ref_busy_o(ref_busy_o), .ras_n_o(ras_n_o),
  .cas_n_o(cas_n_o), .init_done_o(init_done_o)
);

// File: tb/cbr_refresh_sched_tb.sv
`timescale 1ns/1ps
module cbr_refresh_sched_tb;
  localparam int IW  = 20, IC = 8, RI = 40, IL = 300, MP = 3;
  localparam int TCS = 2, TCH = 3, TRA = 6, TRP = 4;
  localparam int SL  = TCS + TRA + TRP;

  logic clk = 0, rst_n = 0, act_i = 0, ref_gnt_i = 0;
  logic ref_req_o, ref_urgent_o, ref_busy_o, ras_n_o, cas_n_o, init_done_o;

  int checks = 0, failures = 0, cyc = 0, mode = 0;
  int mp = 0, falls = 0, first_fall = -1, rise_cyc = -1, fall_cyc = -1;
  int falls_at_idle_drop = 0, last_busy = -1, last_act = -1, run_len = 0;
  logic busy_p = 0, req_p = 0, idone_p = 0, started = 0, seen_gap = 0;
  logic [1:0] combo_p = 2'b11;
  bit finished = 0;

  cbr_refresh_sched #(.INIT_WAIT(IW), .INIT_CYCLES(IC), .REF_INTERVAL(RI),
    .IDLE_LIMIT(IL), .MAX_PENDING(MP), .T_CSR(TCS), .T_CHR(TCH),
    .T_RAS(TRA), .T_RP(TRP)) u_dut (
    .clk(clk), .rst_n(rst_n), .act_i(act_i), .ref_gnt_i(ref_gnt_i),
    .ref_req_o(ref_req_o), .ref_urgent_o(ref_urgent_o), .ref_busy_o(ref_busy_o),
    .ras_n_o(ras_n_o), .cas_n_o(cas_n_o), .init_done_o(init_done_o));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", rq, act, exp, cyc);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  always @(negedge clk) begin
    #1;
    ref_gnt_i <= (mode == 1) || (mode == 2 && ref_urgent_o);
  end

  // per-cycle monitor
  always @(negedge clk) begin
    if (rst_n) begin
      logic [1:0] combo;
      int a;
      // R5/R6/R7 owed-count model
      if (cyc % RI == 0) begin
        if (!(busy_p && !ref_busy_o && idone_p) && mp < MP) mp++;
      end else if (busy_p && !ref_busy_o && idone_p && mp > 0) mp--;
      chk(ref_urgent_o == (mp == MP), "R7 urgent", ref_urgent_o, mp == MP);
      chk(ref_req_o == (init_done_o && mp != 0 && !ref_busy_o), "R5 request",
          ref_req_o, init_done_o && mp != 0 && !ref_busy_o);
      if (!init_done_o) chk(!ref_req_o, "R3 no request in init", ref_req_o, 0);
      if (req_p && ref_gnt_i)
        chk(!cas_n_o && ras_n_o, "R6 grant starts cycle", {ras_n_o, cas_n_o}, 2);
      if (idone_p && !req_p && !busy_p)
        chk(cas_n_o && ras_n_o, "R10 stray grant ignored", {ras_n_o, cas_n_o}, 3);
      if (!ref_busy_o) chk(cas_n_o && ras_n_o, "R4 quiet when free", {ras_n_o, cas_n_o}, 3);
      // R4 phase lengths
      combo = {ras_n_o, cas_n_o};
      if (combo != combo_p) begin
        case (combo_p)
          2'b10: begin
            chk(combo == 2'b00, "R4 ras follows cas", combo, 0);
            chk(run_len == TCS, "R4 cas setup length", run_len, TCS);
          end
          2'b00: begin
            chk(combo == 2'b01, "R4 cas rises first", combo, 1);
            chk(run_len == TCH, "R4 cas hold length", run_len, TCH);
          end
          2'b01: begin
            chk(combo == 2'b11, "R4 ras rises", combo, 3);
            chk(run_len == TRA - TCH, "R4 ras-only length", run_len, TRA - TCH);
          end
          default: begin
            chk(combo == 2'b10, "R4 cas falls first", combo, 2);
            if (seen_gap) chk(run_len >= TRP, "R4 precharge length", run_len, TRP);
            falls++;
            if (first_fall < 0) first_fall = cyc;
          end
        endcase
        if (combo_p == 2'b01) seen_gap = 1;
        run_len = 1;
      end else run_len++;
      combo_p = combo;
      // R3/R8 init edges
      if (init_done_o && !idone_p) begin
        if (rise_cyc < 0) begin
          chk(cyc == IW + IC * (SL + 1), "R3 init_done rise cycle", cyc, IW + IC * (SL + 1));
          chk(falls == IC, "R3 init cycle count", falls, IC);
        end else begin
          chk(cyc - fall_cyc == IC * (SL + 1), "R8 reinit duration", cyc - fall_cyc, IC * (SL + 1));
          chk(falls - falls_at_idle_drop == IC, "R8 reinit cycle count",
              falls - falls_at_idle_drop, IC);
        end
        rise_cyc = cyc;
      end
      if (!init_done_o && idone_p) begin
        a = (last_busy + 1 > last_act) ? last_busy + 1 : last_act;
        chk(cyc == a + IL, "R8 idle drop cycle", cyc, a + IL);
        fall_cyc = cyc;
        falls_at_idle_drop = falls;
      end
      if (ref_busy_o) last_busy = cyc;
      if (act_i) last_act = cyc;
      busy_p = ref_busy_o; req_p = ref_req_o; idone_p = init_done_o;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(ras_n_o && cas_n_o, "R1 strobes high in reset", {ras_n_o, cas_n_o}, 3);
    chk(!init_done_o && !ref_req_o && !ref_busy_o, "R1 flags low in reset",
        {init_done_o, ref_req_o, ref_busy_o}, 0);
    #1 rst_n = 1;
    while (!init_done_o) @(negedge clk);
    chk(first_fall == IW + 1, "R2 power-up pause", first_fall, IW + 1);
    // R9: activity keeps the block initialized, no grants given
    for (int i = 0; i < 8; i++) begin
      repeat (99) @(negedge clk);
      #1 act_i = 1;
      @(negedge clk);
      #1 act_i = 0;
    end
    chk(init_done_o == 1, "R9 activity keeps init", init_done_o, 1);
    chk(rise_cyc == IW + IC * (SL + 1), "R9 no reinit happened", rise_cyc, IW + IC * (SL + 1));
    chk(ref_urgent_o == 1, "R7 saturated while ungranted", ref_urgent_o, 1);
    mode = 1; repeat (600) @(negedge clk);
    mode = 2; repeat (400) @(negedge clk);
    mode = 0;
    while (fall_cyc < 0) @(negedge clk);
    while (!init_done_o) @(negedge clk);
    chk(ref_urgent_o == (mp == MP), "R8 owed count kept", ref_urgent_o, mp == MP);
    mode = 1; repeat (200) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule